// File: doc/BRIEF.md
# Link Interrupt and Cycle-Master Supervisor

This block collects the event flags of a serial-bus link layer and turns them into one level interrupt. Each hardware event arrives as a single-cycle pulse and latches a status bit. Software reads the status word through a small register port and clears bits by writing ones. A per-bit mask selects which latched flags raise the interrupt output.

The same block owns the cycle-master enable. Software may write it directly. It is switched on by itself when auto mode is on and the node comes out of a bus reset as root. It is forced off when a cycle overruns its allowed time. While the node is not cycle master, the block watches cycle-timer rollovers and flags a lost cycle when two come in a row without a cycle-start packet between them.

The cycle timer and the packet receive paths sit outside the block and only deliver pulses to it. Register map: address 0 holds the status, address 1 the mask, address 2 the control word, and address 3 is unused.

Top module: `link_event_supervisor`

## Requirements
- R1: A one-cycle pulse on an event input sets its status bit at the next clock edge. Bit positions: 0 header CRC error, 1 self-ID error, 2 isochronous arbitration failure, 3 cycle overrun, 4 lost cycle (set internally), 5 cycle arbitration failure, 6 PHY interrupt, 7 PHY register received.
- R2: A write to address 0 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R3: When a hardware set and a software clear hit the same status bit in the same clock, the bit ends up set.
- R4: `irq` is a register that is 1 exactly when some status bit and the same bit of the mask (address 1, bits 7:0) are both 1, as those registers stand after the same clock edge.
- R5: A cycle-overrun pulse clears `cm_enable` at the same edge that sets status bit 3. It overrides a software write and an automatic set in that clock.
- R6: When auto mode (control bit 1) is 1 and `bus_reset_done` pulses while `node_is_root` is 1, `cm_enable` becomes 1 at the next edge, unless an overrun or a control write happens in the same clock.
- R7: While `cm_enable` is 0, the second `tmr_rollover` pulse with no `cyc_start_rx` since the previous one sets status bit 4. A `cyc_start_rx` pulse resets the count to zero. A rollover in the same clock as a cycle start is not counted.
- R8: While `cm_enable` is 1, rollovers are not counted, the rollover count is held at zero and no lost cycle is flagged.
- R9: Bits 15:8 of every register read as 0, address 3 reads as 0, and writes to those bits or to address 3 change nothing.
- R10: A write to address 2 loads `cm_enable` from data bit 0 and auto mode from data bit 1. Reading address 2 returns them at the same positions. In the same clock, a control write takes priority over the automatic root set.
- R11: `rd_data` is registered. One edge after `rd_addr` is presented, it shows the addressed register as it stood before that edge.
- R12: While `rst` is high, all status, mask and control bits, the rollover count, `irq`, `cm_enable` and `rd_data` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_hdr_crc | input | 1 | Header CRC error pulse |
| evt_selfid | input | 1 | Self-ID error pulse |
| evt_iso_arb_fail | input | 1 | Isochronous arbitration failure pulse |
| evt_cyc_overrun | input | 1 | Cycle exceeded its allowed time |
| evt_cyc_arb_fail | input | 1 | Cycle arbitration failure pulse |
| evt_phy_int | input | 1 | PHY interrupt pulse |
| evt_phy_reg_rx | input | 1 | PHY register value received pulse |
| tmr_rollover | input | 1 | Cycle-timer rollover pulse |
| cyc_start_rx | input | 1 | Cycle-start packet received pulse |
| bus_reset_done | input | 1 | Bus reset finished pulse |
| node_is_root | input | 1 | Node is root after the bus reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Masked interrupt output |
| cm_enable | output | 1 | Cycle-master enable |

## Verification
Two pairs of functions can land on the same clock. The first pair is a hardware set and a software write-1 clear of the same status bit. The second pair is the forced cycle-master drop on overrun and a control write or root auto-enable that wants the enable high. Directed steps drive both members of each pair in the same cycle, and the random phase makes such overlaps often by using dense event and write rates. A behavioural reference model is compared on every clock, and it judges the outcome by the stated priority: set beats clear, and overrun beats software, which beats the auto set.

// File: rtl/lsup_pkg.sv
package lsup_pkg;
  localparam int NUM_EVT = 8;

  localparam int B_HDR_CRC   = 0;
  localparam int B_SELFID    = 1;
  localparam int B_ISO_ARB   = 2;
  localparam int B_OVERRUN   = 3;
  localparam int B_LOST      = 4;
  localparam int B_CYC_ARB   = 5;
  localparam int B_PHY_INT   = 6;
  localparam int B_PHY_REG   = 7;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_MASK   = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;

  localparam int C_CM_EN = 0;
  localparam int C_AUTO  = 1;

  typedef struct packed {
    logic auto_mode;
    logic cm_en;
  } ctrl_t;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)           q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign sts_o[i] = q;
  end
endmodule

// File: rtl/cycle_loss_det.sv
module cycle_loss_det #(
  parameter int ROLLS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rollover_i,
  input  logic cyc_start_i,
  input  logic cm_active_i,
  output logic lost_o
);
  localparam int CNT_W = $clog2(ROLLS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROLLS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             counting;

  assign counting = rollover_i && !cyc_start_i && !cm_active_i;
  assign lost_o   = counting && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || cyc_start_i || cm_active_i) cnt_q <= '0;
    else if (lost_o)                       cnt_q <= '0;
    else if (counting)                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cm_enable_ctrl.sv
module cm_enable_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic overrun_i,
  input  logic sw_wr_i,
  input  logic sw_cm_i,
  input  logic sw_auto_i,
  input  logic reset_done_i,
  input  logic is_root_i,
  output logic cm_en_o,
  output logic auto_o
);
  logic cm_q, auto_q, auto_set;

  assign auto_set = auto_q && reset_done_i && is_root_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_q   <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      if (sw_wr_i) auto_q <= sw_auto_i;
      if (overrun_i)     cm_q <= 1'b0;
      else if (sw_wr_i)  cm_q <= sw_cm_i;
      else if (auto_set) cm_q <= 1'b1;
    end
  end

  assign cm_en_o = cm_q;
  assign auto_o  = auto_q;
endmodule

// File: rtl/link_event_supervisor.sv
module link_event_supervisor
  import lsup_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int ROLLS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_hdr_crc,
  input  logic              evt_selfid,
  input  logic              evt_iso_arb_fail,
  input  logic              evt_cyc_overrun,
  input  logic              evt_cyc_arb_fail,
  input  logic              evt_phy_int,
  input  logic              evt_phy_reg_rx,
  input  logic              tmr_rollover,
  input  logic              cyc_start_rx,
  input  logic              bus_reset_done,
  input  logic              node_is_root,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              cm_enable
);
  logic [NUM_EVT-1:0] set_vec, clr_vec, sts_q, mask_q, mask_d;
  logic               lost_pulse, auto_q, wr_sts, wr_mask, wr_ctrl;
  logic [DATA_W-1:0]  rd_word;
  ctrl_t              ctrl_view;

  assign wr_sts  = wr_en && (wr_addr == ADDR_W'(A_STATUS));
  assign wr_mask = wr_en && (wr_addr == ADDR_W'(A_MASK));
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));

  always_comb begin
    set_vec            = '0;
    set_vec[B_HDR_CRC] = evt_hdr_crc;
    set_vec[B_SELFID]  = evt_selfid;
    set_vec[B_ISO_ARB] = evt_iso_arb_fail;
    set_vec[B_OVERRUN] = evt_cyc_overrun;
    set_vec[B_LOST]    = lost_pulse;
    set_vec[B_CYC_ARB] = evt_cyc_arb_fail;
    set_vec[B_PHY_INT] = evt_phy_int;
    set_vec[B_PHY_REG] = evt_phy_reg_rx;
  end

  assign clr_vec = wr_sts ? wr_data[NUM_EVT-1:0] : '0;

  evt_status_bank #(.N(NUM_EVT)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .sts_o(sts_q)
  );

  cycle_loss_det #(.ROLLS(ROLLS)) u_loss (
    .clk(clk), .rst(rst), .rollover_i(tmr_rollover), .cyc_start_i(cyc_start_rx),
    .cm_active_i(cm_enable), .lost_o(lost_pulse)
  );

  cm_enable_ctrl u_cm (
    .clk(clk), .rst(rst), .overrun_i(evt_cyc_overrun), .sw_wr_i(wr_ctrl),
    .sw_cm_i(wr_data[C_CM_EN]), .sw_auto_i(wr_data[C_AUTO]),
    .reset_done_i(bus_reset_done), .is_root_i(node_is_root),
    .cm_en_o(cm_enable), .auto_o(auto_q)
  );

  assign mask_d = wr_mask ? wr_data[NUM_EVT-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  // Interrupt follows the next-state of status and mask so it lines up with them.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(((sts_q & ~clr_vec) | set_vec) & mask_d);
  end

  assign ctrl_view = '{auto_mode: auto_q, cm_en: cm_enable};

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      ADDR_W'(A_STATUS): rd_word[NUM_EVT-1:0] = sts_q;
      ADDR_W'(A_MASK):   rd_word[NUM_EVT-1:0] = mask_q;
      ADDR_W'(A_CTRL):   rd_word[1:0]         = ctrl_view;
      default:           rd_word              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end
endmodule

// File: rtl/link_event_supervisor_chk.sv
module link_event_supervisor_chk
  import lsup_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_hdr_crc,
  input logic              evt_cyc_overrun,
  input logic              bus_reset_done,
  input logic              node_is_root,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic              cm_enable,
  input logic [NUM_EVT-1:0] sts_q,
  input logic [NUM_EVT-1:0] mask_q,
  input logic [NUM_EVT-1:0] set_vec,
  input logic              auto_q,
  input logic              lost_pulse
);
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    evt_hdr_crc |=> sts_q[B_HDR_CRC]); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(A_STATUS)) |=>
      ((sts_q & $past(wr_data[NUM_EVT-1:0]) & ~$past(set_vec)) == '0)); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq == |(sts_q & mask_q)); // R4

  AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (rst)
    evt_cyc_overrun |=> (!cm_enable && sts_q[B_OVERRUN])); // R5

  AST_AUTO_ROOT: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_done && node_is_root && auto_q && !evt_cyc_overrun &&
     !(wr_en && wr_addr == ADDR_W'(A_CTRL))) |=> cm_enable); // R6

  AST_LOST_ONLY_SLAVE: assert property (@(posedge clk) disable iff (rst)
    lost_pulse |-> !cm_enable); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:NUM_EVT] == '0); // R9
endmodule

bind link_event_supervisor link_event_supervisor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .evt_hdr_crc(evt_hdr_crc), .evt_cyc_overrun(evt_cyc_overrun),
  .bus_reset_done(bus_reset_done), .node_is_root(node_is_root), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
  .cm_enable(cm_enable), .sts_q(sts_q), .mask_q(mask_q), .set_vec(set_vec),
  .auto_q(auto_q), .lost_pulse(lost_pulse)
);

// File: tb/sim_link_event_supervisor.sv
`timescale 1ns/1ps
module sim_link_event_supervisor;
  logic clk = 0, rst = 1;
  logic e_hdr = 0, e_sid = 0, e_iso = 0, e_ovr = 0, e_arb = 0, e_pint = 0, e_preg = 0;
  logic roll = 0, cstart = 0, brd = 0, root = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic irq, cm_enable;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  link_event_supervisor u0 (
    .clk(clk), .rst(rst), .evt_hdr_crc(e_hdr), .evt_selfid(e_sid),
    .evt_iso_arb_fail(e_iso), .evt_cyc_overrun(e_ovr), .evt_cyc_arb_fail(e_arb),
    .evt_phy_int(e_pint), .evt_phy_reg_rx(e_preg), .tmr_rollover(roll),
    .cyc_start_rx(cstart), .bus_reset_done(brd), .node_is_root(root),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .cm_enable(cm_enable)
  );

  // Behavioural reference model
  bit [7:0] m_sts, m_mask;
  bit m_cm, m_auto, m_irq;
  int m_cnt;
  bit [15:0] m_rd;

  always @(posedge clk) begin
    bit [7:0] setv, clrv;
    bit lost;
    if (rst) begin
      m_sts = 0; m_mask = 0; m_cm = 0; m_auto = 0; m_irq = 0; m_cnt = 0; m_rd = 0;
    end else begin
      case (rd_addr)
        2'd0: m_rd = {8'h00, m_sts};
        2'd1: m_rd = {8'h00, m_mask};
        2'd2: m_rd = {14'h0, m_auto, m_cm};
        default: m_rd = 16'h0;
      endcase
      lost = 0;
      if (cstart || m_cm) m_cnt = 0;
      else if (roll) begin
        m_cnt++;
        if (m_cnt >= 2) begin lost = 1; m_cnt = 0; end
      end
      setv = {e_preg, e_pint, e_arb, lost, e_ovr, e_iso, e_sid, e_hdr};
      clrv = (wr_en && wr_addr == 2'd0) ? wr_data[7:0] : 8'h00;
      m_sts = (m_sts & ~clrv) | setv;
      if (wr_en && wr_addr == 2'd1) m_mask = wr_data[7:0];
      if (e_ovr) m_cm = 0;
      else if (wr_en && wr_addr == 2'd2) m_cm = wr_data[0];
      else if (m_auto && brd && root) m_cm = 1;
      if (wr_en && wr_addr == 2'd2) m_auto = wr_data[1];
      m_irq = |(m_sts & m_mask);
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R4 irq vs model", int'(irq), int'(m_irq));
      chk("R5/R6/R10 cm_enable vs model", int'(cm_enable), int'(m_cm));
      chk("R11 rd_data vs model", int'(rd_data), int'(m_rd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    {e_hdr, e_sid, e_iso, e_ovr, e_arb, e_pint, e_preg} = '0;
    roll = 0; cstart = 0; brd = 0; wr_en = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; step(); v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 irq after reset", irq, 0);
    chk("R12 cm_enable after reset", cm_enable, 0);
    rd(2'd0, v); chk("R12 status after reset", v, 0);
    rd(2'd2, v); chk("R12 control after reset", v, 0);

    // R1 event latching
    e_hdr = 1; e_preg = 1; step();
    rd(2'd0, v); chk("R1 status bits 0 and 7", v, 'h81);
    chk("R4 irq masked off", irq, 0);
    wr(2'd1, 16'h0001);
    chk("R4 irq with mask bit 0", irq, 1);

    // R2 write-one-to-clear
    wr(2'd0, 16'h0080);
    rd(2'd0, v); chk("R2 clear bit 7 only", v, 'h01);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R2 zero write no effect", v, 'h01);

    // R3 set wins over clear
    e_hdr = 1; wr(2'd0, 16'h0001);
    rd(2'd0, v); chk("R3 set beats clear", v, 'h01);
    wr(2'd0, 16'h00FF);
    chk("R4 irq drops after clear", irq, 0);

    // R10 control write, R5 overrun priority
    wr(2'd2, 16'h0003);
    rd(2'd2, v); chk("R10 control readback", v, 3);
    e_ovr = 1; wr(2'd2, 16'h0003);
    chk("R5 overrun beats write", cm_enable, 0);
    rd(2'd0, v); chk("R5 overrun status bit 3", v, 'h08);
    wr(2'd0, 16'h00FF);

    // R6 auto set on root
    brd = 1; root = 1; step();
    chk("R6 auto enable on root", cm_enable, 1);
    brd = 1; wr(2'd2, 16'h0002);
    chk("R10 control write beats auto set", cm_enable, 0);
    brd = 1; root = 0; step();
    chk("R6 no auto set when not root", cm_enable, 0);

    // R7 lost cycle detection
    roll = 1; step(); roll = 1; step();
    rd(2'd0, v); chk("R7 lost after two rollovers", v, 'h10);
    wr(2'd0, 16'h00FF);
    roll = 1; step(); cstart = 1; step(); roll = 1; step();
    rd(2'd0, v); chk("R7 cycle start resets count", v, 0);
    roll = 1; cstart = 1; step(); roll = 1; step();
    rd(2'd0, v); chk("R7 rollover with start not counted", v, 0);
    cstart = 1; step();

    // R8 no counting while cycle master
    wr(2'd2, 16'h0001);
    roll = 1; step(); roll = 1; step(); roll = 1; step();
    rd(2'd0, v); chk("R8 no lost while master", v, 0);
    roll = 1; step();
    wr(2'd2, 16'h0000);
    roll = 1; step();
    rd(2'd0, v); chk("R8 count held at zero", v, 0);
    roll = 1; step();
    rd(2'd0, v); chk("R7 lost after second rollover", v, 'h10);
    wr(2'd0, 16'h00FF);

    // R9 reserved bits and address
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R9 unused address reads zero", v, 0);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R9 mask upper bits zero", v, 'hFF);
    rd(2'd2, v); chk("R9 control unaffected by addr 3", v, 0);

    // Random phase with dense overlaps
    for (int i = 0; i < 6000; i++) begin
      {e_hdr, e_sid, e_iso, e_arb, e_pint, e_preg} = 6'($urandom & $urandom & $urandom);
      e_ovr  = ($urandom_range(0, 15) == 0);
      roll   = ($urandom_range(0, 2) == 0);
      cstart = ($urandom_range(0, 4) == 0);
      brd    = ($urandom_range(0, 7) == 0);
      root   = $urandom_range(0, 1);
      rd_addr = 2'($urandom);
      wr_en  = ($urandom_range(0, 3) == 0);
      wr_addr = 2'($urandom);
      wr_data = 16'($urandom);
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule